// File: doc/BRIEF.md
# Backdoor Key Security Unlock Controller

This block keeps the security state of a chip and lets trusted firmware lift that security for the rest of the current power-on session. While reset is held, it copies a nonvolatile options byte into a live options register. That byte carries three things: a key-permission bit, a bit that turns off vector redirection, and a two-bit security code. Firmware cannot write the live register. A new value takes effect only after the nonvolatile byte is reprogrammed and the chip is reset again.

To unlock, firmware writes a stream of key bytes. Each write is tagged as coming either from the CPU or from the debug port. The block compares the CPU-sourced bytes one by one, in order, against a stored key.

- If every byte matches, the live security code becomes the unsecured value, binary 10.
- If a byte does not match, the attempt is abandoned and no further attempts are taken until the next reset.
- A strobe reporting a passed blank check also unsecures the chip.
- Every unlock, by either route, lasts only until the next reset.

Top module: `key_unlock_ctrl`

## Requirements
- R1: While `rst_n` is low on a rising clock edge, the live options byte `opt_live` loads `nv_opt` with bits 5..2 forced to 0. No other input can change bits 7 and 6 of `opt_live` outside reset.
- R2: `key_en` equals `opt_live[7]`. `vec_redir_en` is 1 when `opt_live[6]` is 0 and 0 when it is 1. `sec_code` equals `opt_live[1:0]`.
- R3: `secure` is 0 when `sec_code` is 2'b10 and 1 for every other code.
- R4: When `key_en` is 0, no sequence of key writes changes `sec_code`.
- R5: A key write with `key_from_cpu` = 0 (debug source) is ignored: it neither counts toward nor aborts an attempt.
- R6: CPU key writes are compared in order against stored bytes 0 to 7, where byte i is `nv_key[8*i+7:8*i]`. When the eighth consecutive byte matches, `sec_code` reads 2'b10 from the clock edge that accepts that write.
- R7: A mismatching CPU key byte aborts the attempt. After that, a correct key sequence has no effect until the next reset.
- R8: A `blank_ok` pulse sets `sec_code` to 2'b10 at the next clock edge, whatever the value of `key_en`.
- R9: An unlock lasts until reset only. The next reset restores `sec_code` from `nv_opt[1:0]`, and without a reset the code stays 2'b10.
- R10: Key writes accepted while `sec_code` is already 2'b10 leave it at 2'b10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; reloads the options byte |
| nv_opt | input | 8 | Nonvolatile options byte image |
| nv_key | input | 8*KEY_BYTES | Stored key; byte i at bits 8*i+7:8*i |
| key_wr | input | 1 | Key byte write strobe |
| key_from_cpu | input | 1 | 1: write issued by CPU, 0: by debug port |
| key_data | input | 8 | Key byte being written |
| blank_ok | input | 1 | Blank check passed strobe |
| opt_live | output | 8 | Live options byte |
| key_en | output | 1 | Backdoor key permitted |
| vec_redir_en | output | 1 | Vector redirection active |
| sec_code | output | 2 | Live security code |
| secure | output | 1 | Chip is secured |

## Verification
The bench builds the block with the default `KEY_BYTES` of 8, so every unlock uses the full eight-byte sequence. This lets the tests reach several corner cases: a mismatch on the very last byte, a fully reversed key order, and debug writes mixed into an attempt that still succeeds. It also covers a correct sequence sent only from the debug port. With the stored key made of distinct bytes, any slip in the byte counter turns into a visible mismatch and a lockout.

// File: rtl/key_unlock_ctrl.sv
module key_unlock_ctrl #(
  parameter int KEY_BYTES = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [7:0]             nv_opt,
  input  logic [8*KEY_BYTES-1:0] nv_key,
  input  logic                   key_wr,
  input  logic                   key_from_cpu,
  input  logic [7:0]             key_data,
  input  logic                   blank_ok,
  output logic [7:0]             opt_live,
  output logic                   key_en,
  output logic                   vec_redir_en,
  output logic [1:0]             sec_code,
  output logic                   secure
);

  localparam int IDX_W = (KEY_BYTES > 1) ? $clog2(KEY_BYTES) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(KEY_BYTES - 1);
  localparam logic [1:0] OPEN = 2'b10;

  logic [7:0]       opt_q;
  logic [IDX_W-1:0] idx_q;
  logic             lock_q;
  logic [7:0]       want;
  logic             take;

  assign want = nv_key[{idx_q, 3'b000} +: 8];
  assign take = key_wr && key_from_cpu && opt_q[7] && (opt_q[1:0] != OPEN) && !lock_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      opt_q  <= nv_opt & 8'hC3;
      idx_q  <= '0;
      lock_q <= 1'b0;
    end else if (blank_ok) begin
      opt_q[1:0] <= OPEN;
      idx_q      <= '0;
    end else if (take) begin
      if (key_data != want) begin
        lock_q <= 1'b1;
        idx_q  <= '0;
      end else if (idx_q == LAST) begin
        opt_q[1:0] <= OPEN;
        idx_q      <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign opt_live     = opt_q;
  assign key_en       = opt_q[7];
  assign vec_redir_en = !opt_q[6];
  assign sec_code     = opt_q[1:0];
  assign secure       = (opt_q[1:0] != OPEN);

  // R1
  opt_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($stable(key_en) && $stable(vec_redir_en)));

  // R4
  keyen_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!key_en && !blank_ok) |=> $stable(sec_code));

  // R5
  dbg_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && !key_from_cpu && !blank_ok) |=> ($stable(idx_q) && $stable(lock_q)));

  // R8
  blank_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blank_ok |=> (sec_code == OPEN));

  // R9
  open_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_code == OPEN) |=> (sec_code == OPEN && !secure));

  // R7
  lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && !blank_ok) |=> (lock_q && $stable(sec_code)));

endmodule

// File: tb/key_unlock_ctrl_bench.sv
module key_unlock_ctrl_bench;
  localparam int KB = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    nv_opt = 8'h00;
  logic [8*KB-1:0] nv_key = 64'h8877665544332211;
  logic          key_wr = 1'b0;
  logic          key_from_cpu = 1'b0;
  logic [7:0]    key_data = 8'h00;
  logic          blank_ok = 1'b0;
  logic [7:0]    opt_live;
  logic          key_en, vec_redir_en, secure;
  logic [1:0]    sec_code;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  key_unlock_ctrl #(.KEY_BYTES(KB)) u_key_unlock_ctrl (
    .clk(clk), .rst_n(rst_n), .nv_opt(nv_opt), .nv_key(nv_key),
    .key_wr(key_wr), .key_from_cpu(key_from_cpu), .key_data(key_data),
    .blank_ok(blank_ok), .opt_live(opt_live), .key_en(key_en),
    .vec_redir_en(vec_redir_en), .sec_code(sec_code), .secure(secure));

  // {cpu, data, expected secure}
  localparam logic [9:0] VEC [12] = '{
    {1'b1, 8'h11, 1'b1}, {1'b0, 8'hFF, 1'b1}, {1'b1, 8'h22, 1'b1},
    {1'b1, 8'h33, 1'b1}, {1'b0, 8'h00, 1'b1}, {1'b1, 8'h44, 1'b1},
    {1'b1, 8'h55, 1'b1}, {1'b1, 8'h66, 1'b1}, {1'b1, 8'h77, 1'b1},
    {1'b0, 8'h88, 1'b1}, {1'b1, 8'h88, 1'b0}, {1'b1, 8'h99, 1'b0}};

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic do_reset(input logic [7:0] opt);
    @(negedge clk);
    nv_opt = opt;
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic cpu, input logic [7:0] d);
    key_wr = 1'b1;
    key_from_cpu = cpu;
    key_data = d;
    @(negedge clk);
    key_wr = 1'b0;
  endtask

  task automatic send_key(input logic cpu, input logic rev);
    for (int i = 0; i < KB; i++) begin
      int k;
      k = rev ? KB - 1 - i : i;
      wr(cpu, nv_key[8*k +: 8]);
    end
  endtask

  initial begin
    #4ms;
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1 R2 R3 reset state
    do_reset(8'hFD);
    check("R1 opt_live", opt_live, 8'hC1);
    check("R2 key_en", {7'd0, key_en}, 8'd1);
    check("R2 vec_redir_en", {7'd0, vec_redir_en}, 8'd0);
    check("R3 secure", {7'd0, secure}, 8'd1);

    do_reset(8'h3E);
    check("R1 opt_live", opt_live, 8'h02);
    check("R2 vec_redir_en", {7'd0, vec_redir_en}, 8'd1);
    check("R3 secure open code", {7'd0, secure}, 8'd0);

    // table walk: R5 R6 R10
    do_reset(8'h81);
    for (int i = 0; i < 12; i++) begin
      wr(VEC[i][9], VEC[i][8:1]);
      check("R6 R5 R10 table secure", {7'd0, secure}, {7'd0, VEC[i][0]});
    end
    check("R10 code stays open", {6'd0, sec_code}, 8'h02);

    // R9 reset relocks
    do_reset(8'h81);
    check("R9 code restored", {6'd0, sec_code}, 8'h01);
    check("R2 R1 key_en reload", {7'd0, key_en}, 8'd1);

    // R4 key disabled
    do_reset(8'h03);
    send_key(1'b1, 1'b0);
    check("R4 key disabled", {6'd0, sec_code}, 8'h03);

    // R5 debug-only sequence
    do_reset(8'h80);
    send_key(1'b0, 1'b0);
    check("R5 debug sequence ignored", {6'd0, sec_code}, 8'h00);
    send_key(1'b1, 1'b0);
    check("R5 cpu after debug unlocks", {6'd0, sec_code}, 8'h02);

    // R6 R7 reversed order then correct
    do_reset(8'h80);
    send_key(1'b1, 1'b1);
    check("R6 reversed order", {7'd0, secure}, 8'd1);
    send_key(1'b1, 1'b0);
    check("R7 locked out", {7'd0, secure}, 8'd1);
    do_reset(8'h80);
    send_key(1'b1, 1'b0);
    check("R7 reset clears lockout", {7'd0, secure}, 8'd0);

    // R6 last byte mismatch
    do_reset(8'h80);
    for (int i = 0; i < KB - 1; i++) wr(1'b1, nv_key[8*i +: 8]);
    wr(1'b1, 8'h00);
    check("R6 last byte mismatch", {6'd0, sec_code}, 8'h00);
    send_key(1'b1, 1'b0);
    check("R7 lockout after last miss", {6'd0, sec_code}, 8'h00);

    // R8 blank check, key disabled, and after lockout
    do_reset(8'h01);
    blank_ok = 1'b1;
    @(negedge clk);
    blank_ok = 1'b0;
    check("R8 blank unlock", {6'd0, sec_code}, 8'h02);
    check("R8 R3 secure low", {7'd0, secure}, 8'd0);
    check("R1 opt_live after blank", opt_live, 8'h02);
    @(negedge clk);
    check("R9 stays open", {6'd0, sec_code}, 8'h02);
    do_reset(8'h80);
    wr(1'b1, 8'hEE);
    blank_ok = 1'b1;
    @(negedge clk);
    blank_ok = 1'b0;
    check("R8 blank after lockout", {6'd0, sec_code}, 8'h02);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule